// File: doc/BRIEF.md
# Bus Integrity Checksum Unit

This unit protects one request/grant/response memory port. On the request side it drives, with no register in the path, an odd-parity companion for the request strobe and a 12-bit address-phase checksum. The checksum covers the address, the access attributes, the debug flag, the atomic-operation field and the write data. On the response side it compares the incoming grant parity, the valid parity and a 5-bit response checksum against the values they should hold. It also counts accepted transactions, so a response that arrives when nothing is outstanding can be reported.

Checking needs two enables. The first is a global integrity enable. The second is a per-access integrity attribute, which is sampled in the address phase. At grant, the attribute and the load/store direction are pushed into a small queue. Each response is then judged against the attribute and direction of its own access, whatever the inputs are doing when that response arrives. A detected fault gives a registered error flag with an 11-bit cause code, 1026 for a load and 1027 for a store, and raises the major alert. A stray response raises the major alert alone. A build parameter selects an instruction-fetch variant, which forms the checksum with fixed byte enables, no write, no atomic operation and zero write data.

Top module: `bus_integ_unit`

## Requirements
- R1: `reqpar_o` is the inverse of `req_i` in the same cycle, for both values of `req_i`.
- R2: `achk_o[3:0]` are the even-parity bits (XOR) of address bytes 0..3. `achk_o[11:8]` are the even-parity bits of write-data bytes 0..3, formed from all 32 data bits even when `we_i` is 0 or the byte enables select fewer bytes. All of these appear in the same cycle.
- R3: `achk_o[4]` is the inverted XOR of `prot_i` and `memtype_i`. `achk_o[5]` is the inverted XOR of `be_i` and `we_i`. `achk_o[6]` is the inverse of `dbg_i`. `achk_o[7]` is the XOR of `atop_i`.
- R4: With `FETCH_SIDE`=1, the checksum is formed as if `be_i`=4'b1111, `we_i`=0, `atop_i`=0 and `wdata_i`=0, whatever is driven on those inputs.
- R5: A grant-parity check runs in every cycle with `req_i`=1, `integ_en_i`=1 and `acc_integ_i`=1. When `gntpar_i` equals `gnt_i` in such a cycle, `integ_err_o` is 1 in the next cycle, with code 1027 if `we_i`=1 and 1026 otherwise.
- R6: While at least one transaction is outstanding, the oldest access's attribute governs the response checks. If `rvalidpar_i` equals `rvalid_i`, that is an error. On a response, `rchk_i[4]` must equal `err_i`. For a read only, `rchk_i[3:0]` must be the even-parity bits of all four `rdata_i` bytes. A fault gives `integ_err_o` in the next cycle, with code 1026 for a load and 1027 for a store.
- R7: No check reports anything while `integ_en_i`=0. A response whose access had `acc_integ_i`=0 at grant is not checked, even if the attribute is 1 when the response arrives.
- R8: A response (`rvalid_i`=1) with zero outstanding transactions sets `major_alert_o` in the next cycle and does not set `integ_err_o`.
- R9: `major_alert_o` is 1 in every cycle in which `integ_err_o` is 1. `integ_code_o` is 0 whenever `integ_err_o` is 0.
- R10: The outstanding count increments on `req_i & gnt_i`, decrements on an accepted response, and saturates at `MAX_OUTST` (default 2). A grant taken at the limit, with no response in the same cycle, is not counted, so its response counts as stray.
- R11: If an address-phase fault and a response fault occur in the same cycle, the code reported is the one for the response.
- R12: After reset, `integ_err_o`, `major_alert_o` and `integ_code_o` are 0 and no transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| integ_en_i | input | 1 | Global integrity enable |
| req_i | input | 1 | Request strobe |
| addr_i | input | 32 | Address |
| we_i | input | 1 | Write enable (1 = store) |
| be_i | input | 4 | Byte enables |
| prot_i | input | 3 | Protection attribute |
| memtype_i | input | 2 | Memory type attribute |
| dbg_i | input | 1 | Debug-mode access flag |
| atop_i | input | 6 | Atomic operation field |
| wdata_i | input | 32 | Write data |
| acc_integ_i | input | 1 | Per-access integrity attribute, sampled with the request |
| gnt_i | input | 1 | Grant |
| gntpar_i | input | 1 | Grant odd-parity companion |
| rvalid_i | input | 1 | Response valid |
| rvalidpar_i | input | 1 | Response-valid odd-parity companion |
| rdata_i | input | 32 | Read data |
| err_i | input | 1 | Response error |
| rchk_i | input | 5 | Response checksum |
| reqpar_o | output | 1 | Request odd-parity companion |
| achk_o | output | 12 | Address-phase checksum |
| integ_err_o | output | 1 | Parity/checksum fault (registered) |
| integ_code_o | output | 11 | Fault cause: 1026 load, 1027 store, 0 none |
| major_alert_o | output | 1 | Major alert (registered) |

## Verification
`reqpar_o` and `achk_o` are combinational. The bench reads them a moment after it drives the request fields, with no clock edge in between. `integ_err_o`, `integ_code_o` and `major_alert_o` are due one edge after the cycle that holds the faulty grant, response or stray valid. Each scenario drives its inputs at a falling edge, lets one rising edge pass, and samples at the next falling edge, then returns the inputs to a clean idle state before the next scenario. The outstanding-count effects (capture of the attribute at grant, saturation, stray detection) are followed across several such cycles, one response per cycle.

// File: rtl/bus_integ_pkg.sv
package bus_integ_pkg;

  localparam int unsigned CODE_W = 11;
  localparam logic [CODE_W-1:0] CODE_LOAD  = 11'd1026;
  localparam logic [CODE_W-1:0] CODE_STORE = 11'd1027;
  localparam int unsigned ACHK_W = 12;
  localparam int unsigned RCHK_W = 5;

  typedef struct packed {
    logic integ;
    logic we;
  } txn_attr_t;

  // even-parity bit of a byte: XOR of its bits
  function automatic logic byte_even(input logic [7:0] b);
    return ^b;
  endfunction

  function automatic logic [ACHK_W-1:0] achk_calc(
    input logic [31:0] addr,
    input logic        we,
    input logic [3:0]  be,
    input logic [2:0]  prot,
    input logic [1:0]  memtype,
    input logic        dbg,
    input logic [5:0]  atop,
    input logic [31:0] wdata
  );
    logic [ACHK_W-1:0] c;
    for (int i = 0; i < 4; i++) begin
      c[i]   = byte_even(addr[8*i +: 8]);
      c[8+i] = byte_even(wdata[8*i +: 8]);
    end
    c[4] = ~(^{prot, memtype});
    c[5] = ~(^{be, we});
    c[6] = ~dbg;
    c[7] = ^atop;
    return c;
  endfunction

  function automatic logic [RCHK_W-1:0] rchk_calc(
    input logic [31:0] rdata,
    input logic        err
  );
    logic [RCHK_W-1:0] c;
    for (int i = 0; i < 4; i++) begin
      c[i] = byte_even(rdata[8*i +: 8]);
    end
    c[4] = err ^ 1'b0;  // exclusive-okay is tied low
    return c;
  endfunction

endpackage

// File: rtl/bus_integ_req_gen.sv
module bus_integ_req_gen
  import bus_integ_pkg::*;
#(
  parameter bit FETCH_SIDE = 1'b0
) (
  input  logic              req_i,
  input  logic [31:0]       addr_i,
  input  logic              we_i,
  input  logic [3:0]        be_i,
  input  logic [2:0]        prot_i,
  input  logic [1:0]        memtype_i,
  input  logic              dbg_i,
  input  logic [5:0]        atop_i,
  input  logic [31:0]       wdata_i,
  output logic              reqpar_o,
  output logic [ACHK_W-1:0] achk_o
);

  logic        eff_we;
  logic [3:0]  eff_be;
  logic [5:0]  eff_atop;
  logic [31:0] eff_wdata;

  generate
    if (FETCH_SIDE) begin : g_fetch
      assign eff_we    = 1'b0;
      assign eff_be    = 4'b1111;
      assign eff_atop  = '0;
      assign eff_wdata = '0;
    end else begin : g_data
      assign eff_we    = we_i;
      assign eff_be    = be_i;
      assign eff_atop  = atop_i;
      assign eff_wdata = wdata_i;
    end
  endgenerate

  assign reqpar_o = ~req_i;
  assign achk_o   = achk_calc(addr_i, eff_we, eff_be, prot_i, memtype_i,
                              dbg_i, eff_atop, eff_wdata);

endmodule

// File: rtl/bus_integ_txn_track.sv
module bus_integ_txn_track
  import bus_integ_pkg::*;
#(
  parameter int unsigned MAX_OUTST = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_i,
  input  logic      gnt_i,
  input  logic      rvalid_i,
  input  txn_attr_t push_attr_i,
  output txn_attr_t head_attr_o,
  output logic      empty_o,
  output logic [$clog2(MAX_OUTST+1)-1:0] cnt_o
);

  localparam int unsigned CNT_W = $clog2(MAX_OUTST + 1);
  localparam int unsigned PTR_W = (MAX_OUTST > 1) ? $clog2(MAX_OUTST) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_OUTST);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MAX_OUTST - 1);

  txn_attr_t        slots [MAX_OUTST];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             full, push, pop;

  assign empty_o = (cnt == '0);
  assign full    = (cnt == CNT_MAX);
  assign pop     = rvalid_i & ~empty_o;
  assign push    = req_i & gnt_i & (~full | pop);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_attr_i;
  end

  assign head_attr_o = slots[rd_ptr];
  assign cnt_o       = cnt;

endmodule

// File: rtl/bus_integ_resp_chk.sv
module bus_integ_resp_chk
  import bus_integ_pkg::*;
(
  input  logic              integ_en_i,
  input  logic              rvalid_i,
  input  logic              rvalidpar_i,
  input  logic [31:0]       rdata_i,
  input  logic              err_i,
  input  logic [RCHK_W-1:0] rchk_i,
  input  txn_attr_t         head_attr_i,
  input  logic              empty_i,
  output logic              resp_fault_o,
  output logic              resp_we_o,
  output logic              stray_o
);

  logic [RCHK_W-1:0] rchk_exp;
  logic              active, par_bad, err_bad, data_bad;

  assign rchk_exp = rchk_calc(rdata_i, err_i);
  assign active   = integ_en_i & head_attr_i.integ & ~empty_i;
  assign par_bad  = (rvalidpar_i == rvalid_i);
  assign err_bad  = rvalid_i & (rchk_i[4] != rchk_exp[4]);
  assign data_bad = rvalid_i & ~head_attr_i.we & (rchk_i[3:0] != rchk_exp[3:0]);

  assign resp_fault_o = active & (par_bad | err_bad | data_bad);
  assign resp_we_o    = head_attr_i.we;
  assign stray_o      = rvalid_i & empty_i;

endmodule

// File: rtl/bus_integ_unit.sv
module bus_integ_unit
  import bus_integ_pkg::*;
#(
  parameter bit          FETCH_SIDE = 1'b0,
  parameter int unsigned MAX_OUTST  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        integ_en_i,
  input  logic        req_i,
  input  logic [31:0] addr_i,
  input  logic        we_i,
  input  logic [3:0]  be_i,
  input  logic [2:0]  prot_i,
  input  logic [1:0]  memtype_i,
  input  logic        dbg_i,
  input  logic [5:0]  atop_i,
  input  logic [31:0] wdata_i,
  input  logic        acc_integ_i,
  input  logic        gnt_i,
  input  logic        gntpar_i,
  input  logic        rvalid_i,
  input  logic        rvalidpar_i,
  input  logic [31:0] rdata_i,
  input  logic        err_i,
  input  logic [4:0]  rchk_i,
  output logic        reqpar_o,
  output logic [11:0] achk_o,
  output logic        integ_err_o,
  output logic [10:0] integ_code_o,
  output logic        major_alert_o
);

  localparam int unsigned CNT_W = $clog2(MAX_OUTST + 1);

  // named internal events, visible to the bound checker
  txn_attr_t        push_attr, head_attr;
  logic             outst_empty;
  logic [CNT_W-1:0] outst_cnt;
  logic             addr_fault, resp_fault, resp_we, stray_rsp;
  logic             fault_any;
  logic [CODE_W-1:0] fault_code;

  bus_integ_req_gen #(.FETCH_SIDE(FETCH_SIDE)) u_req_gen (
    .req_i     (req_i),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .be_i      (be_i),
    .prot_i    (prot_i),
    .memtype_i (memtype_i),
    .dbg_i     (dbg_i),
    .atop_i    (atop_i),
    .wdata_i   (wdata_i),
    .reqpar_o  (reqpar_o),
    .achk_o    (achk_o)
  );

  assign push_attr.integ = acc_integ_i;
  assign push_attr.we    = FETCH_SIDE ? 1'b0 : we_i;

  bus_integ_txn_track #(.MAX_OUTST(MAX_OUTST)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .gnt_i       (gnt_i),
    .rvalid_i    (rvalid_i),
    .push_attr_i (push_attr),
    .head_attr_o (head_attr),
    .empty_o     (outst_empty),
    .cnt_o       (outst_cnt)
  );

  bus_integ_resp_chk u_resp_chk (
    .integ_en_i   (integ_en_i),
    .rvalid_i     (rvalid_i),
    .rvalidpar_i  (rvalidpar_i),
    .rdata_i      (rdata_i),
    .err_i        (err_i),
    .rchk_i       (rchk_i),
    .head_attr_i  (head_attr),
    .empty_i      (outst_empty),
    .resp_fault_o (resp_fault),
    .resp_we_o    (resp_we),
    .stray_o      (stray_rsp)
  );

  // address phase: grant parity must be the complement of grant
  assign addr_fault = integ_en_i & acc_integ_i & req_i & (gntpar_i == gnt_i);
  assign fault_any  = addr_fault | resp_fault;

  // the response belongs to an older access, so it wins the code
  always_comb begin
    fault_code = '0;
    if (resp_fault)      fault_code = resp_we ? CODE_STORE : CODE_LOAD;
    else if (addr_fault) fault_code = push_attr.we ? CODE_STORE : CODE_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_err_o   <= 1'b0;
      integ_code_o  <= '0;
      major_alert_o <= 1'b0;
    end else begin
      integ_err_o   <= fault_any;
      integ_code_o  <= fault_code;
      major_alert_o <= fault_any | stray_rsp;
    end
  end

endmodule

// File: rtl/bus_integ_chk.sv
module bus_integ_chk #(
  parameter int unsigned MAX_OUTST = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        integ_en_i,
  input logic        rvalid_i,
  input logic        outst_empty,
  input logic [$clog2(MAX_OUTST+1)-1:0] outst_cnt,
  input logic        integ_err_o,
  input logic [10:0] integ_code_o,
  input logic        major_alert_o
);

  a_r8_stray_alert: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_i && outst_empty) |=> major_alert_o);

  a_r9_err_alert: assert property (@(posedge clk) disable iff (!rst_n)
    integ_err_o |-> major_alert_o);

  a_r9_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !integ_err_o |-> (integ_code_o == 11'd0));

  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    integ_err_o |-> (integ_code_o == 11'd1026 || integ_code_o == 11'd1027));

  a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !integ_en_i |=> !integ_err_o);

  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    outst_cnt <= ($clog2(MAX_OUTST+1))'(MAX_OUTST));

endmodule

bind bus_integ_unit bus_integ_chk #(.MAX_OUTST(MAX_OUTST)) u_integ_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .integ_en_i    (integ_en_i),
  .rvalid_i      (rvalid_i),
  .outst_empty   (outst_empty),
  .outst_cnt     (outst_cnt),
  .integ_err_o   (integ_err_o),
  .integ_code_o  (integ_code_o),
  .major_alert_o (major_alert_o)
);

// File: tb/test_bus_integ_unit.sv
`timescale 1ns/1ps
module test_bus_integ_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        integ_en, req, we, dbg, acc_integ, gnt, gntpar, rvalid, rvalidpar, err;
  logic [31:0] addr, wdata, rdata;
  logic [3:0]  be;
  logic [2:0]  prot;
  logic [1:0]  memtype;
  logic [5:0]  atop;
  logic [4:0]  rchk;
  logic        reqpar, f_reqpar, ierr, alert;
  logic [11:0] achk, f_achk;
  logic [10:0] code;
  logic        f_ierr, f_alert;
  logic [10:0] f_code;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  bus_integ_unit i_bus_integ_unit (
    .clk(clk), .rst_n(rst_n), .integ_en_i(integ_en), .req_i(req), .addr_i(addr),
    .we_i(we), .be_i(be), .prot_i(prot), .memtype_i(memtype), .dbg_i(dbg),
    .atop_i(atop), .wdata_i(wdata), .acc_integ_i(acc_integ), .gnt_i(gnt),
    .gntpar_i(gntpar), .rvalid_i(rvalid), .rvalidpar_i(rvalidpar), .rdata_i(rdata),
    .err_i(err), .rchk_i(rchk), .reqpar_o(reqpar), .achk_o(achk),
    .integ_err_o(ierr), .integ_code_o(code), .major_alert_o(alert)
  );

  bus_integ_unit #(.FETCH_SIDE(1'b1)) i_bus_integ_unit_fetch (
    .clk(clk), .rst_n(rst_n), .integ_en_i(1'b0), .req_i(req), .addr_i(addr),
    .we_i(we), .be_i(be), .prot_i(prot), .memtype_i(memtype), .dbg_i(dbg),
    .atop_i(atop), .wdata_i(wdata), .acc_integ_i(1'b0), .gnt_i(1'b0),
    .gntpar_i(1'b1), .rvalid_i(1'b0), .rvalidpar_i(1'b1), .rdata_i(32'd0),
    .err_i(1'b0), .rchk_i(5'd0), .reqpar_o(f_reqpar), .achk_o(f_achk),
    .integ_err_o(f_ierr), .integ_code_o(f_code), .major_alert_o(f_alert)
  );

  // parity by bit count: even-parity bit is 1 when the count is odd
  function automatic logic ev(input logic [31:0] v);
    return ($countones(v) % 2) == 1;
  endfunction

  function automatic logic [11:0] model_achk(input logic [31:0] a, input logic w,
      input logic [3:0] b, input logic [2:0] p, input logic [1:0] m, input logic d,
      input logic [5:0] at, input logic [31:0] wd);
    logic [11:0] r;
    r[0] = ev({24'd0, a[7:0]});   r[1] = ev({24'd0, a[15:8]});
    r[2] = ev({24'd0, a[23:16]}); r[3] = ev({24'd0, a[31:24]});
    r[4] = !ev({27'd0, p, m});    r[5] = !ev({27'd0, b, w});
    r[6] = !d;                    r[7] = ev({26'd0, at});
    r[8] = ev({24'd0, wd[7:0]});  r[9] = ev({24'd0, wd[15:8]});
    r[10] = ev({24'd0, wd[23:16]}); r[11] = ev({24'd0, wd[31:24]});
    return r;
  endfunction

  function automatic logic [4:0] model_rchk(input logic [31:0] d, input logic e);
    return {e, ev({24'd0, d[31:24]}), ev({24'd0, d[23:16]}),
            ev({24'd0, d[15:8]}), ev({24'd0, d[7:0]})};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    req = 0; gnt = 0; gntpar = 1; rvalid = 0; rvalidpar = 1;
    rdata = 0; err = 0; rchk = 0; we = 0; acc_integ = 1; integ_en = 1;
  endtask

  // one rising edge, then observe at the falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic grant(input logic w, input logic ai, input logic gp_ok);
    idle(); req = 1; gnt = 1; we = w; acc_integ = ai; gntpar = gp_ok ? 1'b0 : 1'b1;
    step();
  endtask

  task automatic respond(input logic [31:0] d, input logic e, input logic [4:0] flip,
                         input logic vp_ok);
    idle(); rvalid = 1; rvalidpar = vp_ok ? 1'b0 : 1'b1; rdata = d; err = e;
    rchk = model_rchk(d, e) ^ flip;
    step();
  endtask

  task automatic t_reset();
    chk("R12 err after reset", ierr, 0);
    chk("R12 alert after reset", alert, 0);
    chk("R12 code after reset", code, 0);
    chk("R1 reqpar idle", reqpar, 1);
    // nothing outstanding: a response is stray
    respond(32'h0, 0, 0, 1);
    chk("R12 empty after reset -> stray alert", alert, 1);
    idle(); step();
  endtask

  task automatic t_request_side();
    logic [31:0] av [4] = '{32'h0000_0000, 32'hA5C3_0F01, 32'hFFFF_FFFF, 32'h1234_5678};
    logic [31:0] wv [4] = '{32'h8000_0001, 32'h0, 32'h7F7F_0103, 32'hDEAD_BEEF};
    for (int i = 0; i < 4; i++) begin
      idle();
      req = i[0]; addr = av[i]; wdata = wv[i]; we = i[1]; be = 4'(i * 5 + 1);
      prot = 3'(i + 2); memtype = 2'(i); dbg = i[0]; atop = 6'(i * 11);
      #1;
      chk("R1 reqpar", reqpar, !req);
      chk("R2 R3 achk", achk, model_achk(addr, we, be, prot, memtype, dbg, atop, wdata));
      chk("R4 fetch achk", f_achk, model_achk(addr, 1'b0, 4'hF, prot, memtype, dbg, 6'd0, 32'd0));
    end
    // write-data bytes still count on a sub-word read
    we = 0; be = 4'b0001; wdata = 32'h0100_0000; #1;
    chk("R2 wdata checksum on read", achk[11], 1);
    idle(); step();
  endtask

  task automatic t_grant_parity();
    grant(1, 1, 0);
    chk("R5 store grant parity err", ierr, 1);
    chk("R5 store code", code, 1027);
    chk("R9 alert with err", alert, 1);
    // store response with wrong data checksum is not checked (R6)
    respond(32'hFFFF_0000, 0, 5'b01111, 1);
    chk("R6 store ignores data checksum", ierr, 0);
    grant(0, 1, 0);
    chk("R5 load code", code, 1026);
    respond(32'h1, 0, 0, 1);
    chk("R9 code zero when no err", code, 0);
    chk("R9 no alert on good response", alert, 0);
  endtask

  task automatic t_response_faults();
    grant(0, 1, 1);
    chk("R5 good grant no err", ierr, 0);
    respond(32'h0102_0304, 0, 5'b01000, 1);  // sub-word read, top byte corrupt
    chk("R6 load data checksum err", ierr, 1);
    chk("R6 load code", code, 1026);
    grant(0, 1, 1);
    respond(32'h55, 0, 0, 0);
    chk("R6 valid parity err", ierr, 1);
    grant(1, 1, 1);
    respond(32'h0, 1, 5'b10000, 1);
    chk("R6 err-bit checksum store", code, 1027);
  endtask

  task automatic t_enables();
    integ_en = 0;
    idle(); integ_en = 0; req = 1; gnt = 1; gntpar = 1; acc_integ = 1; step();
    chk("R7 global off grant", ierr, 0);
    idle(); integ_en = 0; rvalid = 1; rvalidpar = 1; rchk = 5'h1F; step();
    chk("R7 global off response", ierr, 0);
    grant(0, 0, 0);
    chk("R7 attribute off grant", ierr, 0);
    respond(32'hFF, 0, 5'b00001, 1);  // attribute is 1 now, but 0 at grant
    chk("R7 attribute captured at grant", ierr, 0);
    chk("R7 no alert", alert, 0);
  endtask

  task automatic t_stray_and_saturate();
    respond(32'h0, 0, 0, 1);
    chk("R8 stray alert", alert, 1);
    chk("R8 stray no err", ierr, 0);
    grant(0, 1, 1); grant(0, 1, 1); grant(0, 1, 1);  // third over the limit
    respond(32'h3, 0, 0, 1);
    chk("R10 first response ok", alert, 0);
    respond(32'h4, 0, 0, 1);
    chk("R10 second response ok", alert, 0);
    respond(32'h5, 0, 0, 1);
    chk("R10 saturated grant uncounted -> stray", alert, 1);
  endtask

  task automatic t_priority();
    grant(1, 1, 1);  // outstanding store
    idle(); req = 1; gnt = 1; we = 0; gntpar = 1;     // bad load grant
    rvalid = 1; rvalidpar = 1;                         // bad store response
    step();
    chk("R11 response code wins", code, 1027);
    respond(32'h0, 0, 0, 1);
    chk("R11 drain", ierr, 0);
  endtask

  initial begin
    idle(); addr = 0; wdata = 0; be = 0; prot = 0; memtype = 0; dbg = 0; atop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_request_side();
    t_grant_parity();
    t_response_faults();
    t_enables();
    t_stray_and_saturate();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule